// File: doc/BRIEF.md
# Stop-Mode Wakeup Stabilization Sequencer

This block tracks the power state of a small controller and drives its clock enables. There are four states: running, where both the CPU clock and the peripheral clocks are enabled; idle, where the CPU clock is gated and the peripherals keep running; stop, where both are gated and the oscillator is treated as halted; and a stabilization wait, which looks like idle from outside. During that wait only the stabilization timer counts, and the CPU stays halted.

Two events bring the block out of stop. The first is a reset, which always waits 2^RST_EXP oscillator cycles before the CPU restarts. The second is a qualified rising edge on the external interrupt line, which waits a length chosen by a 2-bit select input. The select value is sampled at the moment of wakeup. A recognised interrupt in idle returns the block to running at once, with no wait. The interrupt line is synchronised and then glitch-filtered, so only pulses that last a minimum number of cycles count as wake events.

Top module: `pwr_stab_seq`

## Requirements
- R1: While `rst_n` is low the block is in the wait state. After `rst_n` rises, the state becomes running after exactly 2^RST_EXP rising clock edges (default 2^16).
- R2: `state_o` uses running=0, idle=1, stop=2, wait=3. The clock enables are: running, cpu=1 and per=1; idle, cpu=0 and per=1; stop, cpu=0 and per=0; wait, cpu=0 and per=1.
- R3: In running, `stop_req` high at a clock edge moves the block to stop. This holds even when `idle_req` is high at the same edge. `idle_req` alone moves the block to idle.
- R4: In idle, a recognised interrupt edge moves the block straight to running at the next edge and never passes through wait. `stop_req` is ignored in idle.
- R5: Stop is held until a recognised interrupt edge arrives. `stop_req` and `idle_req` have no effect in stop.
- R6: An interrupt wake from stop enters wait for 2^E cycles. E is picked by `wait_sel` at the wake edge: 0 gives SEL_EXP0 (default 8), 1 gives SEL_EXP1 (11), 2 gives SEL_EXP2 (13), and 3 gives SEL_EXP3 (16).
- R7: During wait, `stop_req`, `idle_req`, further interrupts and changes to `wait_sel` are ignored. The wait length and the return to running are unchanged.
- R8: An interrupt counts only when the synchronised line has held high for MIN_PULSE consecutive cycles. A pulse that is held for MIN_PULSE-1 cycles never wakes the block.
- R9: Reset overrides a pending or concurrent interrupt. If the interrupt line is high across the release of reset, the wait still lasts exactly 2^RST_EXP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset; also a wake source |
| stop_req | input | 1 | Request to enter stop (acted on in running only) |
| idle_req | input | 1 | Request to enter idle (acted on in running only) |
| irq_in | input | 1 | Raw external interrupt line |
| wait_sel | input | 2 | Selects the interrupt-wake stabilization length |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| state_o | output | 2 | Current power state |

## Verification
The bench measures every wait in edges from entry to running, for the reset and for all four select codes. A counter that is off by one, or a table that maps the codes to the wrong lengths, therefore shows up as a wrong count. It drives a pulse one cycle shorter than the filter minimum; a filter that is too lax would wake the block from stop. It toggles `wait_sel` and pulses `stop_req` in the middle of a wait. A design that reloads the timer or honours the request would lengthen the wait or fall back into stop. It also holds the interrupt line high across a reset release, where a design that lets the interrupt win would use a select-based length. The idle wake is watched cycle by cycle, so a detour through the wait state is caught.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
   typedef enum logic [1:0] {
      PS_RUN  = 2'd0,
      PS_IDLE = 2'd1,
      PS_STOP = 2'd2,
      PS_WAIT = 2'd3
   } pwr_state_e;
endpackage

// File: rtl/irq_filter.sv
module irq_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_PULSE   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic rise_o
);
   localparam int CW = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_filter: SYNC_STAGES must be at least 2");
   end
   if (MIN_PULSE < 1) begin : g_bad_pulse
      $error("irq_filter: MIN_PULSE must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   level_q;
   logic                   rise_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   if (MIN_PULSE == 1) begin : g_nofilt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            level_q <= 1'b0;
            rise_q  <= 1'b0;
         end else begin
            level_q <= synced;
            rise_q  <= synced & ~level_q;
         end
      end
   end else begin : g_filt
      logic [CW-1:0] run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            level_q <= 1'b0;
            rise_q  <= 1'b0;
            run_q   <= '0;
         end else begin
            rise_q <= 1'b0;
            if (synced != level_q) begin
               if (run_q == CW'(MIN_PULSE - 1)) begin
                  level_q <= synced;
                  rise_q  <= synced;
                  run_q   <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end else begin
               run_q <= '0;
            end
         end
      end
   end

   assign rise_o = rise_q;

   // R8: a filtered level only changes toward the value the synchroniser held
   a_r8_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(level_q) |-> ($past(synced) == level_q));
   // R8: a recognised edge is a single-cycle event
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/stab_timer.sv
module stab_timer #(
   parameter int CNT_W    = 16,
   parameter int RST_EXP  = 16,
   parameter int SEL_EXP0 = 8,
   parameter int SEL_EXP1 = 11,
   parameter int SEL_EXP2 = 13,
   parameter int SEL_EXP3 = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  logic [1:0] sel_i,
   input  logic       count_i,
   output logic       done_o
);
   localparam int NSEL = 4;

   function automatic int exp_of(input int idx);
      case (idx)
         0:       return SEL_EXP0;
         1:       return SEL_EXP1;
         2:       return SEL_EXP2;
         default: return SEL_EXP3;
      endcase
   endfunction

   localparam logic [CNT_W-1:0] RST_M1 = CNT_W'((longint'(1) << RST_EXP) - 1);

   if (RST_EXP < 1 || RST_EXP > CNT_W) begin : g_bad_rst
      $error("stab_timer: RST_EXP out of range");
   end

   logic [CNT_W-1:0] len_m1 [NSEL];

   for (genvar g = 0; g < NSEL; g++) begin : g_len
      localparam int EXP = exp_of(g);
      if (EXP < 1 || EXP > CNT_W) begin : g_bad_sel
         $error("stab_timer: select exponent out of range");
      end
      assign len_m1[g] = CNT_W'((longint'(1) << EXP) - 1);
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RST_M1;
      end else if (load_i) begin
         cnt_q <= len_m1[sel_i];
      end else if (count_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done_o = (cnt_q == '0);

   // R6: the wait counts down by one per edge while running
   a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (count_i && !load_i && !done_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
   // R7: with no load, an idle timer never moves
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
   import pwr_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_req_i,
   input  logic       idle_req_i,
   input  logic       wake_i,
   input  logic       timer_done_i,
   output pwr_state_e state_o,
   output logic       load_o,
   output logic       count_o
);
   pwr_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         PS_RUN: begin
            if (stop_req_i)      state_d = PS_STOP;
            else if (idle_req_i) state_d = PS_IDLE;
         end
         PS_IDLE: if (wake_i)       state_d = PS_RUN;
         PS_STOP: if (wake_i)       state_d = PS_WAIT;
         PS_WAIT: if (timer_done_i) state_d = PS_RUN;
         default:                   state_d = PS_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_WAIT;
      else        state_q <= state_d;
   end

   assign state_o = state_q;
   assign load_o  = (state_q == PS_STOP) && wake_i;
   assign count_o = (state_q == PS_WAIT);

   // R3: stop request wins in running
   a_r3_stop_first: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_RUN && stop_req_i) |=> (state_q == PS_STOP));
   // R4: idle wake returns straight to running
   a_r4_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_IDLE && wake_i) |=> (state_q == PS_RUN));
   // R5: stop holds without a wake
   a_r5_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_STOP && !wake_i) |=> (state_q == PS_STOP));
   // R6: a stop wake enters the wait
   a_r6_stop_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_STOP && wake_i) |=> (state_q == PS_WAIT));
   // R7: wait holds until the timer expires
   a_r7_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_WAIT && !timer_done_i) |=> (state_q == PS_WAIT));
endmodule

// File: rtl/pwr_stab_seq.sv
module pwr_stab_seq
   import pwr_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_PULSE   = 4,
   parameter int RST_EXP     = 16,
   parameter int SEL_EXP0    = 8,
   parameter int SEL_EXP1    = 11,
   parameter int SEL_EXP2    = 13,
   parameter int SEL_EXP3    = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_req,
   input  logic       idle_req,
   input  logic       irq_in,
   input  logic [1:0] wait_sel,
   output logic       cpu_clk_en,
   output logic       per_clk_en,
   output logic [1:0] state_o
);
   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int CNT_W = max2(max2(RST_EXP, SEL_EXP0),
                               max2(max2(SEL_EXP1, SEL_EXP2), SEL_EXP3));

   if (CNT_W > 30) begin : g_bad_width
      $error("pwr_stab_seq: wait exponents too large");
   end

   logic       wake;
   logic       t_done;
   logic       t_load;
   logic       t_count;
   pwr_state_e st;

   irq_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .MIN_PULSE   (MIN_PULSE)
   ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (irq_in),
      .rise_o (wake)
   );

   stab_timer #(
      .CNT_W    (CNT_W),
      .RST_EXP  (RST_EXP),
      .SEL_EXP0 (SEL_EXP0),
      .SEL_EXP1 (SEL_EXP1),
      .SEL_EXP2 (SEL_EXP2),
      .SEL_EXP3 (SEL_EXP3)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (t_load),
      .sel_i   (wait_sel),
      .count_i (t_count),
      .done_o  (t_done)
   );

   pwr_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .stop_req_i   (stop_req),
      .idle_req_i   (idle_req),
      .wake_i       (wake),
      .timer_done_i (t_done),
      .state_o      (st),
      .load_o       (t_load),
      .count_o      (t_count)
   );

   assign state_o    = st;
   assign cpu_clk_en = (st == PS_RUN);
   assign per_clk_en = (st != PS_STOP);

   // R2: the CPU clock never runs without the peripheral clock
   a_r2_cpu_needs_per: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en |-> per_clk_en);
   // R1: leaving the wait always lands in running
   a_r1_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd3) |=> (state_o == 2'd3 || state_o == 2'd0));
endmodule

// File: tb/test_pwr_stab_seq.sv
module test_pwr_stab_seq;
   localparam int RE = 7;
   localparam int E0 = 3;
   localparam int E1 = 4;
   localparam int E2 = 5;
   localparam int E3 = 6;
   localparam int MP = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stop_req = 1'b0;
   logic       idle_req = 1'b0;
   logic       irq_in = 1'b0;
   logic [1:0] wait_sel = 2'd0;
   logic       cpu_clk_en;
   logic       per_clk_en;
   logic [1:0] state_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pwr_stab_seq #(
      .SYNC_STAGES (2),
      .MIN_PULSE   (MP),
      .RST_EXP     (RE),
      .SEL_EXP0    (E0),
      .SEL_EXP1    (E1),
      .SEL_EXP2    (E2),
      .SEL_EXP3    (E3)
   ) i_pwr_stab_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .stop_req   (stop_req),
      .idle_req   (idle_req),
      .irq_in     (irq_in),
      .wait_sel   (wait_sel),
      .cpu_clk_en (cpu_clk_en),
      .per_clk_en (per_clk_en),
      .state_o    (state_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_out(input string req, input int st, input int cpu, input int per);
      chk(req, "state", int'(state_o), st);
      chk(req, "cpu_clk_en", int'(cpu_clk_en), cpu);
      chk(req, "per_clk_en", int'(per_clk_en), per);
   endtask

   task automatic count_wait(output int n);
      n = 0;
      while (state_o == 2'd3 && n < 100000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic settle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic to_stop();
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
   endtask

   task automatic irq_pulse(input int hold);
      irq_in = 1'b1;
      repeat (hold) @(negedge clk);
      irq_in = 1'b0;
   endtask

   task automatic t_reset();
      int n;
      settle(3);
      chk_out("R1", 3, 0, 1);
      rst_n = 1'b1;
      count_wait(n);
      chk("R1", "reset wait length", n, 1 << RE);
      chk_out("R2", 0, 1, 1);
   endtask

   task automatic t_idle();
      bit saw_wait;
      settle(12);
      idle_req = 1'b1;
      @(negedge clk);
      idle_req = 1'b0;
      chk_out("R3", 1, 0, 1);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      settle(2);
      chk("R4", "stop_req ignored in idle", int'(state_o), 1);
      irq_pulse(MP);
      saw_wait = 1'b0;
      for (int i = 0; i < 30 && state_o == 2'd1; i++) begin
         @(negedge clk);
         if (state_o == 2'd3) saw_wait = 1'b1;
      end
      chk("R4", "idle wake reaches running", int'(state_o), 0);
      chk("R4", "idle wake skipped wait", int'(saw_wait), 0);
   endtask

   task automatic t_stop_prio();
      settle(12);
      stop_req = 1'b1;
      idle_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      idle_req = 1'b0;
      chk_out("R3", 2, 0, 0);
      idle_req = 1'b1;
      @(negedge clk);
      idle_req = 1'b0;
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      settle(3);
      chk("R5", "requests ignored in stop", int'(state_o), 2);
      irq_pulse(MP - 1);
      settle(20);
      chk("R8", "short pulse rejected", int'(state_o), 2);
   endtask

   task automatic t_sel(input int sel, input int exp_len);
      int n;
      settle(12);
      if (state_o != 2'd2) to_stop();
      wait_sel = 2'(sel);
      irq_pulse(MP);
      for (int i = 0; i < 30 && state_o == 2'd2; i++) @(negedge clk);
      chk_out("R2", 3, 0, 1);
      n = 0;
      while (state_o == 2'd3 && n < 100000) begin
         if (n == 2) begin
            stop_req = 1'b1;
            idle_req = 1'b1;
            wait_sel = ~wait_sel;
         end else begin
            stop_req = 1'b0;
            idle_req = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      stop_req = 1'b0;
      idle_req = 1'b0;
      chk("R6", $sformatf("wait length sel %0d", sel), n, exp_len);
      settle(1);
      chk("R7", "requests in wait ignored", int'(state_o), 0);
   endtask

   task automatic t_rst_prio();
      int n;
      settle(12);
      to_stop();
      irq_in = 1'b1;
      settle(2);
      rst_n = 1'b0;
      settle(3);
      chk("R9", "reset state", int'(state_o), 3);
      rst_n = 1'b1;
      count_wait(n);
      chk("R9", "wait length with irq high", n, 1 << RE);
      irq_in = 1'b0;
      settle(12);
      chk("R9", "running after reset wake", int'(state_o), 0);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_stop_prio();
      t_sel(0, 1 << E0);
      t_sel(1, 1 << E1);
      to_stop();
      t_sel(2, 1 << E2);
      t_sel(3, 1 << E3);
      t_rst_prio();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule